// File: doc/BRIEF.md
# Return Address Stack Predictor

This block sits beside a fetch unit and guesses where a function return will land. Each time the front end sees a call-type branch, it presents the return address (the value that goes into the link register) and the block stores it on a small last-in, first-out stack. When the front end sees a return, the block pops the newest stored address and offers it as the predicted target. A valid flag tells the fetch unit whether the guess can be used.

Four entries are held by default. If a call arrives while all of them are occupied, the block does not wrap around and does not overwrite the oldest entry. It throws away the whole contents, and the address of that call is dropped too. The next return then reports no valid prediction, and the fetch unit falls back to its ordinary path. A flush input, driven by misprediction recovery, empties the stack in a single cycle. Call and return may be requested in the same cycle. In that case the pop is taken first and the push second, so the top entry is replaced and the depth does not change.

The prediction is registered. Target and valid appear in the cycle after the return request. The target holds its last value until another successful pop.

Top module: `ret_addr_predictor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack is emptied, `pred_valid_o` becomes 0 and `pred_target_o` becomes 0.
- R2: A lone call (`call_i`=1, `ret_i`=0) on a stack that is not full stores `link_addr_i` as the new top. Stored addresses come back in reverse order of their calls, up to DEPTH (4) nested calls.
- R3: A lone return on a non-empty stack drives `pred_target_o` to the top address and `pred_valid_o` to 1 on the next clock edge, and removes that entry.
- R4: A lone return on an empty stack gives `pred_valid_o`=0 on the next edge. It leaves `pred_target_o` unchanged and the stack empty.
- R5: A lone call while DEPTH entries are held discards every entry, including the new address, so the following return gives `pred_valid_o`=0.
- R6: `flush_i`=1 empties the stack within that one edge and overrides `call_i` and `ret_i` in the same cycle: no push, no pop, and `pred_valid_o`=0 next.
- R7: Call and return in the same cycle pop first and then push. On a non-empty stack the old top is output as valid and replaced by `link_addr_i`, with depth unchanged. On an empty stack the output is invalid and `link_addr_i` becomes the only entry.
- R8: In any cycle without a successful pop, `pred_valid_o` is 0 on the next edge and `pred_target_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Misprediction recovery: empty the stack |
| call_i | input | 1 | Call-type branch seen: push `link_addr_i` |
| ret_i | input | 1 | Return seen: pop a predicted target |
| link_addr_i | input | ADDR_W (32) | Return address to store on a call |
| pred_target_o | output | ADDR_W (32) | Predicted return target, registered |
| pred_valid_o | output | 1 | Prediction valid, one cycle after a return |

## Verification
A wrong occupancy count shows up at the ports only when a return arrives. A count that is too high makes an empty stack answer valid with a stale address. A count that is too low makes a filled stack answer invalid, or makes an overflow discard fire one call early or late. A corrupted entry, or a wrong read index, surfaces as a wrong target in the cycle right after the return that reaches it, which may be many calls later. For that reason the stimulus nests calls to full depth and past it, mixes in flushes and same-cycle call/return pairs, and compares every cycle against a queue model.

// File: rtl/rap_pkg.sv
// Package: shared operation encoding for the return address stack predictor.
// Assumes: one operation is chosen per cycle by the controller.
package rap_pkg;

    typedef enum logic [2:0] {
        RAP_IDLE  = 3'd0,  // nothing to do
        RAP_PUSH  = 3'd1,  // store link address on top
        RAP_POP   = 3'd2,  // read top, shrink
        RAP_SWAP  = 3'd3,  // read top, replace it with link address
        RAP_SEED  = 3'd4,  // call+return on empty stack: store at slot 0
        RAP_CLEAR = 3'd5   // flush or overflow discard
    } rap_op_e;

endpackage

// File: rtl/rap_ctrl.sv
// Module: rap_ctrl
// Keeps the occupancy count and turns call/return/flush requests into one
// stack operation per cycle. It gives flush priority. A call on a full stack
// clears everything. Call and return together pop first and then push.
// Assumes: DEPTH >= 2; the request inputs are sampled on the rising clock edge.
module rap_ctrl #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         call_i,
    input  logic                         ret_i,
    output rap_pkg::rap_op_e             op_o,
    output logic [$clog2(DEPTH)-1:0]     wr_idx_o,
    output logic [$clog2(DEPTH)-1:0]     rd_idx_o,
    output logic [$clog2(DEPTH+1)-1:0]   occ_o
);
    import rap_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

    logic [OCC_W-1:0] occ_q;
    logic [OCC_W-1:0] occ_d;
    logic [IDX_W-1:0] top_idx;
    logic             is_empty;
    logic             is_full;
    rap_op_e          op;

    assign is_empty = (occ_q == '0);
    assign is_full  = (occ_q == OCC_FULL);
    assign top_idx  = IDX_W'(occ_q - OCC_W'(1));

    // Choose this cycle's operation from the requests and the fill level.
    always_comb begin
        op = RAP_IDLE;
        if (flush_i) begin
            op = RAP_CLEAR;
        end else if (call_i && ret_i) begin
            op = is_empty ? RAP_SEED : RAP_SWAP;
        end else if (call_i) begin
            op = is_full ? RAP_CLEAR : RAP_PUSH;
        end else if (ret_i) begin
            op = is_empty ? RAP_IDLE : RAP_POP;
        end
    end

    // Next occupancy for each operation.
    always_comb begin
        unique case (op)
            RAP_PUSH:  occ_d = occ_q + OCC_W'(1);
            RAP_POP:   occ_d = occ_q - OCC_W'(1);
            RAP_SEED:  occ_d = OCC_W'(1);
            RAP_CLEAR: occ_d = '0;
            default:   occ_d = occ_q;
        endcase
    end

    // Occupancy register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    // Write slot: one above the top for a push, the top itself for a swap.
    always_comb begin
        unique case (op)
            RAP_PUSH: wr_idx_o = IDX_W'(occ_q);
            RAP_SWAP: wr_idx_o = top_idx;
            default:  wr_idx_o = '0;
        endcase
    end

    assign rd_idx_o = top_idx;
    assign op_o     = op;
    assign occ_o    = occ_q;

endmodule

// File: rtl/rap_store.sv
// Module: rap_store
// Entry array for the stack. Each slot has its own write enable, and the top
// slot is read combinationally. A read and a write in the same cycle return
// the old contents.
// Assumes: the controller never asks to write beyond DEPTH-1.
module rap_store #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  rap_pkg::rap_op_e          op_i,
    input  logic [$clog2(DEPTH)-1:0]  wr_idx_i,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx_i,
    input  logic [ADDR_W-1:0]         wr_data_i,
    output logic [ADDR_W-1:0]         rd_data_o
);
    import rap_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic              any_wr;

    // A write happens on push, swap or seed.
    assign any_wr = (op_i == RAP_PUSH) || (op_i == RAP_SWAP) || (op_i == RAP_SEED);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit;
        // Seed always targets slot 0; push and swap use the given index.
        assign hit = any_wr &&
                     ((op_i == RAP_SEED) ? (g == 0) : (wr_idx_i == IDX_W'(g)));

        // Hold or load this slot; contents need no reset, occupancy guards them.
        always_ff @(posedge clk) begin
            if (hit) slot_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/rap_outreg.sv
// Module: rap_outreg
// Registers the prediction. A pop or swap loads the top address and raises
// valid for one cycle; every other operation drops valid and keeps the target.
// Assumes: rd_data_i is the top entry as read before any write of this cycle.
module rap_outreg #(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  rap_pkg::rap_op_e     op_i,
    input  logic [ADDR_W-1:0]    rd_data_i,
    output logic [ADDR_W-1:0]    target_o,
    output logic                 valid_o
);
    import rap_pkg::*;

    logic take;

    assign take = (op_i == RAP_POP) || (op_i == RAP_SWAP);

    // Capture a predicted target on a successful pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= take;
            if (take) target_o <= rd_data_i;
        end
    end

endmodule

// File: rtl/ret_addr_predictor.sv
// Module: ret_addr_predictor (top)
// Return address stack for a fetch unit. Calls push the link address, returns
// pop a registered predicted target with a valid flag. A flush, or a call on a
// full stack, empties it.
// Assumes: one call and/or one return request per cycle at most.
module ret_addr_predictor #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              call_i,
    input  logic              ret_i,
    input  logic [ADDR_W-1:0] link_addr_i,
    output logic [ADDR_W-1:0] pred_target_o,
    output logic              pred_valid_o
);
    import rap_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int OCC_W = $clog2(DEPTH + 1);

    rap_op_e           op;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic [OCC_W-1:0]  occ;
    logic [ADDR_W-1:0] top_data;

    rap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .op_o     (op),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .occ_o    (occ)
    );

    rap_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .op_i      (op),
        .wr_idx_i  (wr_idx),
        .rd_idx_i  (rd_idx),
        .wr_data_i (link_addr_i),
        .rd_data_o (top_data)
    );

    rap_outreg #(.ADDR_W(ADDR_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .rd_data_i (top_data),
        .target_o  (pred_target_o),
        .valid_o   (pred_valid_o)
    );

endmodule

// File: rtl/rap_checker.sv
// Module: rap_checker
// Concurrent properties for the return address stack predictor, bound to the
// top. It watches the ports and the occupancy count.
// Assumes: synchronous active-low reset on rst_n.
module rap_checker #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       flush_i,
    input logic                       call_i,
    input logic                       ret_i,
    input logic [ADDR_W-1:0]          pred_target_o,
    input logic                       pred_valid_o,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [OCC_W-1:0] OCC_FULL = OCC_W'(DEPTH);

    // R1: reset empties the stack and drops valid
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (occ == '0) && !pred_valid_o);

    // R2: occupancy never exceeds the depth
    p_occ_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OCC_FULL);

    // R3: valid only follows an unflushed return
    p_valid_needs_ret_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid_o |-> $past(ret_i && !flush_i));

    // R4: return on empty gives no prediction and keeps target
    p_empty_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !flush_i && occ == '0)
        |=> !pred_valid_o && $stable(pred_target_o) && occ == '0);

    // R5: call on full stack discards everything
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ret_i && !flush_i && occ == OCC_FULL) |=> occ == '0);

    // R6: flush empties in one cycle and suppresses the prediction
    p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (occ == '0) && !pred_valid_o);

    // R7: call and return together on a non-empty stack keep the depth
    p_swap_depth_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && ret_i && !flush_i && occ != '0)
        |=> $stable(occ) && pred_valid_o);

    // R8: without a return the target holds and valid is low
    p_target_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_i |=> $stable(pred_target_o) && !pred_valid_o);

endmodule

bind ret_addr_predictor rap_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .call_i        (call_i),
    .ret_i         (ret_i),
    .pred_target_o (pred_target_o),
    .pred_valid_o  (pred_valid_o),
    .occ           (occ)
);

// File: tb/sim_ret_addr_predictor.sv
`timescale 1ns/1ps
module sim_ret_addr_predictor;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic              call_i = 1'b0;
    logic              ret_i = 1'b0;
    logic [ADDR_W-1:0] link_addr_i = '0;
    logic [ADDR_W-1:0] pred_target_o;
    logic              pred_valid_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [ADDR_W-1:0] mq[$];
    logic [ADDR_W-1:0] exp_target = '0;
    logic              exp_valid  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    ret_addr_predictor #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .call_i(call_i),
        .ret_i(ret_i), .link_addr_i(link_addr_i),
        .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o)
    );

    task automatic compare(input string tag);
        checks++;
        if (pred_valid_o !== exp_valid || pred_target_o !== exp_target) begin
            errors++;
            $display("FAIL %s: actual valid=%0b target=%h expected valid=%0b target=%h",
                     tag, pred_valid_o, pred_target_o, exp_valid, exp_target);
        end
    endtask

    // One cycle: drive at negedge, model at posedge, compare at next negedge.
    task automatic step(input bit c, input bit r, input bit f,
                        input logic [ADDR_W-1:0] a, input string tag);
        call_i = c; ret_i = r; flush_i = f; link_addr_i = a;
        @(posedge clk);
        if (f) begin
            mq.delete(); exp_valid = 1'b0;
        end else if (c && r) begin
            if (mq.size() > 0) begin
                exp_target = mq.pop_back(); exp_valid = 1'b1;
            end else exp_valid = 1'b0;
            mq.push_back(a);
        end else if (c) begin
            if (mq.size() == DEPTH) mq.delete();
            else mq.push_back(a);
            exp_valid = 1'b0;
        end else if (r) begin
            if (mq.size() > 0) begin
                exp_target = mq.pop_back(); exp_valid = 1'b1;
            end else exp_valid = 1'b0;
        end else exp_valid = 1'b0;
        @(negedge clk);
        compare(tag);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all R): actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;

        step(0, 1, 0, 32'h0, "R4 return on empty");
        step(0, 0, 0, 32'h0, "R8 idle");

        step(1, 0, 0, 32'h1000, "R2 push");
        step(1, 0, 0, 32'h2000, "R2 push");
        step(1, 0, 0, 32'h3000, "R2 push");
        step(0, 1, 0, 32'h0, "R3 pop 3000");
        step(0, 0, 0, 32'h0, "R8 hold after pop");
        step(0, 1, 0, 32'h0, "R3 pop 2000");
        step(0, 1, 0, 32'h0, "R3 pop 1000");
        step(0, 1, 0, 32'h0, "R4 empty after pops");

        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 32'hA000 + i, "R2 fill");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 32'h0, "R2 LIFO full depth");
        step(0, 1, 0, 32'h0, "R4 empty after full drain");

        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 32'hB000 + i, "R2 fill");
        step(1, 0, 0, 32'hBEEF, "R5 overflow call");
        step(0, 1, 0, 32'h0, "R5 return after overflow");
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 32'hC000 + i, "R2 fill");
        step(1, 0, 0, 32'hCAFE, "R5 overflow call");
        step(1, 0, 0, 32'hD00D, "R5 push after discard");
        step(0, 1, 0, 32'h0, "R5 only post-discard entry");
        step(0, 1, 0, 32'h0, "R5 empty again");

        step(1, 0, 0, 32'hE000, "R2 push");
        step(1, 0, 0, 32'hE100, "R2 push");
        step(0, 0, 1, 32'h0, "R6 flush");
        step(0, 1, 0, 32'h0, "R6 return after flush");
        step(1, 0, 0, 32'hE200, "R2 push");
        step(1, 1, 1, 32'hE300, "R6 flush beats call+ret");
        step(0, 1, 0, 32'h0, "R6 empty after combined flush");

        step(1, 0, 0, 32'hF000, "R2 push");
        step(1, 1, 0, 32'hF100, "R7 swap outputs old top");
        step(0, 1, 0, 32'h0, "R7 replaced top");
        step(0, 1, 0, 32'h0, "R7 depth unchanged, now empty");
        step(1, 1, 0, 32'hF200, "R7 call+ret on empty");
        step(0, 1, 0, 32'h0, "R7 seeded entry");

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2] & ~lfsr[5], (lfsr[7:3] == 5'd0),
                 {16'h5A00, lfsr}, "R3 mixed traffic");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule